// File: doc/BRIEF.md
# Plane Write-Enable Sequencer Register

This block sits between a host I/O bus and a four-plane display memory. The host first writes a register number to an index port, then reads or writes the chosen register through a shared data port. One of these indexed registers is a four-bit plane mask. Each mask bit opens the write path of one byte-wide memory plane. A single CPU memory write is therefore copied to every enabled plane in the same cycle, with no need to switch one plane at a time.

The CPU memory-write request comes in as one strobe and one data byte. It leaves as four per-plane write enables, each gated by its mask bit, together with a copy of the byte for every plane. The other indexed registers are stubs: they read as zero and keep nothing. Display scan-out is handled elsewhere.

Top module: `planeMaskSeq`

## Requirements
- R1: After reset the index register reads 0x00 and the plane mask reads 0x0F, so all four planes are enabled.
- R2: An I/O write to address 0x3C4 loads the full data byte into the index register at the next clock edge. An I/O read of 0x3C4 returns the current index in the same cycle.
- R3: When the index holds 0x02, an I/O write to 0x3C5 loads data bits 3:0 into the plane mask at the next clock edge. Data bits 7:4 are dropped.
- R4: When the index holds 0x02, an I/O read of 0x3C5 returns the mask in bits 3:0 and zero in bits 7:4. With any other index, a read of 0x3C5 returns 0x00 and a write to 0x3C5 leaves the mask unchanged.
- R5: In a cycle where memWrReq is high, planeWrEn equals the mask in that same cycle. Bit i enables plane i: bit 3 is intensity, bit 2 red, bit 1 green and bit 0 blue in 16-colour mode. When memWrReq is low, planeWrEn is 0.
- R6: If the mask is zero, a memory write raises no plane enable.
- R7: planeWrData carries memWrData to every plane byte in the same cycle. Plane i uses bits 8i+7:8i.
- R8: I/O accesses to any address other than 0x3C4 and 0x3C5 change no register. ioRdData is 0x00 whenever ioRd is low or the address is not one of these two ports.
- R9: If a mask write and a memory write happen in the same cycle, the memory write uses the old mask. The new mask applies from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O bus address |
| ioWrData | input | 8 | I/O write data |
| ioWr | input | 1 | I/O write strobe |
| ioRd | input | 1 | I/O read strobe |
| ioRdData | output | 8 | I/O read data, combinational |
| memWrReq | input | 1 | CPU memory-write request |
| memWrData | input | 8 | CPU memory-write byte |
| planeWrEn | output | 4 | Per-plane write enables |
| planeWrData | output | 32 | Write byte copied to each plane |

## Verification
The assertions assume that ioWr and ioRd are never high together and that every input is stable at the clock edge. The stimulus drives all inputs just after a rising edge and drives only one I/O strobe at a time. The property for stub indices also assumes the index register changes only through port 0x3C4. The stimulus therefore mixes index writes, mask writes, writes to stub indices, writes to foreign addresses and memory writes, including a cycle where a mask write and a memory write coincide.

// File: rtl/planeSeqPkg.sv
package planeSeqPkg;
  // Strobes decoded by control and consumed by the register datapath
  typedef struct packed {
    logic idxWr;   // load index register
    logic maskWr;  // load plane mask
    logic idxRd;   // drive index onto read bus
    logic dataRd;  // drive selected register onto read bus
  } seqStrobe_t;
endpackage

// File: rtl/planeSeqCtrl.sv
module planeSeqCtrl
  import planeSeqPkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h03C4,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h03C5,
  parameter logic [DATA_W-1:0] MASK_INDEX = 8'h02
) (
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [DATA_W-1:0] indexQ,
  output seqStrobe_t        strobe
);
  logic hitIndex;
  logic hitData;
  logic maskSel;

  always_comb begin
    hitIndex = (ioAddr == INDEX_PORT);
    hitData  = (ioAddr == DATA_PORT);
    maskSel  = (indexQ == MASK_INDEX);
    strobe.idxWr  = ioWr && hitIndex;
    strobe.maskWr = ioWr && hitData && maskSel;
    strobe.idxRd  = ioRd && hitIndex;
    strobe.dataRd = ioRd && hitData;
  end
endmodule

// File: rtl/planeSeqRegs.sv
module planeSeqRegs
  import planeSeqPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PLANES = 4,
  parameter logic [DATA_W-1:0] MASK_INDEX = 8'h02
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               strobe,
  input  logic [DATA_W-1:0]        ioWrData,
  input  logic                     memWrReq,
  input  logic [DATA_W-1:0]        memWrData,
  output logic [DATA_W-1:0]        indexQ,
  output logic [PLANES-1:0]        maskQ,
  output logic [DATA_W-1:0]        ioRdData,
  output logic [PLANES-1:0]        planeWrEn,
  output logic [PLANES*DATA_W-1:0] planeWrData
);
  localparam int PAD_W = DATA_W - PLANES;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexQ <= '0;
      maskQ  <= '1;
    end else begin
      if (strobe.idxWr)  indexQ <= ioWrData;
      if (strobe.maskWr) maskQ  <= ioWrData[PLANES-1:0];
    end
  end

  always_comb begin
    ioRdData = '0;
    if (strobe.idxRd) begin
      ioRdData = indexQ;
    end else if (strobe.dataRd && indexQ == MASK_INDEX) begin
      ioRdData = {{PAD_W{1'b0}}, maskQ};
    end
  end

  for (genvar p = 0; p < PLANES; p++) begin : gPlane
    assign planeWrEn[p] = memWrReq & maskQ[p];
    assign planeWrData[p*DATA_W +: DATA_W] = memWrData;
  end
endmodule

// File: rtl/planeMaskSeq.sv
module planeMaskSeq
  import planeSeqPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PLANES = 4,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h03C4,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h03C5,
  parameter logic [DATA_W-1:0] MASK_INDEX = 8'h02
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        ioAddr,
  input  logic [DATA_W-1:0]        ioWrData,
  input  logic                     ioWr,
  input  logic                     ioRd,
  output logic [DATA_W-1:0]        ioRdData,
  input  logic                     memWrReq,
  input  logic [DATA_W-1:0]        memWrData,
  output logic [PLANES-1:0]        planeWrEn,
  output logic [PLANES*DATA_W-1:0] planeWrData
);
  seqStrobe_t          strobe;
  logic [DATA_W-1:0]   indexQ;
  logic [PLANES-1:0]   maskQ;

  planeSeqCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT), .MASK_INDEX(MASK_INDEX)
  ) ctrl (
    .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd), .indexQ(indexQ), .strobe(strobe)
  );

  planeSeqRegs #(
    .DATA_W(DATA_W), .PLANES(PLANES), .MASK_INDEX(MASK_INDEX)
  ) regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ioWrData(ioWrData),
    .memWrReq(memWrReq), .memWrData(memWrData),
    .indexQ(indexQ), .maskQ(maskQ), .ioRdData(ioRdData),
    .planeWrEn(planeWrEn), .planeWrData(planeWrData)
  );
endmodule

// File: rtl/planeMaskSeqChk.sv
module planeMaskSeqChk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PLANES = 4,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h03C4,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h03C5,
  parameter logic [DATA_W-1:0] MASK_INDEX = 8'h02
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic [DATA_W-1:0] ioWrData,
  input logic              ioWr,
  input logic              ioRd,
  input logic [DATA_W-1:0] ioRdData,
  input logic              memWrReq,
  input logic [PLANES-1:0] planeWrEn,
  input logic [DATA_W-1:0] indexQ,
  input logic [PLANES-1:0] maskQ
);
  assert_reset_mask_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (maskQ == '1 && indexQ == '0));

  assert_index_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == INDEX_PORT) |=> indexQ == $past(ioWrData));

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == DATA_PORT && indexQ == MASK_INDEX)
      |=> maskQ == $past(ioWrData[PLANES-1:0]));

  assert_stub_keeps_mask_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioAddr == DATA_PORT && indexQ != MASK_INDEX) |=> $stable(maskQ));

  assert_enables_within_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
    (planeWrEn & ~maskQ) == '0);

  assert_idle_no_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    !memWrReq |-> planeWrEn == '0);

  assert_zero_mask_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> planeWrEn == '0);

  assert_quiet_read_bus_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ioRd |-> ioRdData == '0);
endmodule

bind planeMaskSeq planeMaskSeqChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PLANES(PLANES),
  .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT), .MASK_INDEX(MASK_INDEX)
) chkInst (.*);

// File: tb/tb_planeMaskSeq.sv
`timescale 1ns/1ps
module tb_planeMaskSeq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioWrData = '0;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [7:0]  ioRdData;
  logic        memWrReq = 1'b0;
  logic [7:0]  memWrData = '0;
  logic [3:0]  planeWrEn;
  logic [31:0] planeWrData;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int refIndex = 0;
  int refMask = 15;

  always #5 clk = ~clk;

  planeMaskSeq dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioWr(ioWr), .ioRd(ioRd), .ioRdData(ioRdData),
    .memWrReq(memWrReq), .memWrData(memWrData),
    .planeWrEn(planeWrEn), .planeWrData(planeWrData)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One bus cycle: drive after the edge, compare mid-cycle, update the model at the edge
  task automatic step(string tag, bit wr, bit rd, int addr, int data, bit mw, int mdata);
    int expRd;
    int expEn;
    ioWr = wr; ioRd = rd; ioAddr = 16'(addr); ioWrData = 8'(data);
    memWrReq = mw; memWrData = 8'(mdata);
    #4;
    expRd = 0;
    if (rd && addr == 'h3C4) expRd = refIndex;
    else if (rd && addr == 'h3C5) expRd = (refIndex == 2) ? refMask : 0;
    expEn = mw ? refMask : 0;
    check({tag, " rd"}, int'(ioRdData), expRd);
    check({tag, " en"}, int'(planeWrEn), expEn);
    if (mw) begin
      for (int p = 0; p < 4; p++)
        check({tag, " R7 data"}, int'(planeWrData[p*8 +: 8]), mdata & 255);
    end
    @(posedge clk);
    if (wr && addr == 'h3C4) refIndex = data & 255;
    else if (wr && addr == 'h3C5 && refIndex == 2) refMask = data & 15;
    #1;
    ioWr = 0; ioRd = 0; memWrReq = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset values
    step("R1 idx", 0, 1, 'h3C4, 0, 0, 0);
    step("R2 set idx2", 1, 0, 'h3C4, 2, 0, 0);
    step("R1 mask", 0, 1, 'h3C5, 0, 0, 0);
    step("R5 all planes", 0, 0, 0, 0, 1, 'hA5);
    // R3 mask load with upper bits dropped
    step("R3 wr", 1, 0, 'h3C5, 'hF6, 0, 0);
    step("R3 rd", 0, 1, 'h3C5, 0, 0, 0);
    step("R5 partial", 0, 0, 0, 0, 1, 'h3C);
    for (int m = 0; m < 16; m++) begin
      step("R3 sweep", 1, 0, 'h3C5, m, 0, 0);
      step("R5 sweep", 0, 0, 0, 0, 1, m * 17);
      step("R4 rdback", 0, 1, 'h3C5, 0, 0, 0);
    end
    // R6 zero mask
    step("R6 zero", 1, 0, 'h3C5, 'h00, 0, 0);
    step("R6 mw", 0, 0, 0, 0, 1, 'hFF);
    // R9 simultaneous mask write and memory write
    step("R9 same", 1, 0, 'h3C5, 'h09, 1, 'h5A);
    step("R9 next", 0, 0, 0, 0, 1, 'h5A);
    // R4 stub index
    step("R2 idx7", 1, 0, 'h3C4, 7, 0, 0);
    step("R2 rd", 0, 1, 'h3C4, 0, 0, 0);
    step("R4 stub wr", 1, 0, 'h3C5, 'h0F, 0, 0);
    step("R4 stub rd", 0, 1, 'h3C5, 0, 0, 0);
    step("R4 mask kept", 0, 0, 0, 0, 1, 'h11);
    // R8 foreign addresses
    step("R8 wr", 1, 0, 'h3C6, 'h02, 0, 0);
    step("R8 rd", 0, 1, 'h3C6, 0, 0, 0);
    step("R8 wr2", 1, 0, 'h03C4 ^ 'h100, 'h02, 0, 0);
    step("R8 idx", 0, 1, 'h3C4, 0, 0, 0);
    step("R2 idx2", 1, 0, 'h3C4, 'h02, 0, 0);
    step("R4 mask rd", 0, 1, 'h3C5, 0, 0, 0);
    step("R2 idxFF", 1, 0, 'h3C4, 'hFF, 0, 0);
    step("R2 rdFF", 0, 1, 'h3C4, 0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule